// File: doc/BRIEF.md
# Load/Store Ordering Hazard Matrix

This block keeps loads and stores that are in flight in a group of memory function units in a safe order. Each unit can hold one memory operation. When a unit receives a load, the block notes a read-after-write link to every other unit that already holds a store. When a unit receives a store, it notes a write-after-read link to every unit that already holds a load. A unit whose row holds any live link of its own kind is reported as stalled. The effect is that only a group made up entirely of loads, or entirely of stores, can go ahead at one time, and these groups drain in the order they arrived. Address overlap and register hazards are checked by other logic.

New operations arrive on a valid/ready port that carries a unit index and an op kind. `iss_ready` reflects the unit named on `iss_unit`. It is low when that unit already holds an operation, and an offer made while it is low leaves the block unchanged. The block takes at most one operation per cycle. A completion pulse names a unit. It clears that unit's busy flag, its own row of links, and every link in its column, and this releases the units that were waiting on it.

Top module: `memdep_matrix`

## Requirements
- R1: After reset, no unit is busy, no unit is stalled, and `iss_ready` is high for every unit index.
- R2: An offer is taken when `iss_valid` and `iss_ready` are both high. `iss_ready` is low when the addressed unit is already busy, and an offer made while it is low changes no busy flag and no stall output.
- R3: An accepted load (`iss_is_store`=0) on unit u sets `ld_busy[u]`. If any other unit holds a store, `ld_stall[u]` is high from the cycle after acceptance.
- R4: An accepted store (`iss_is_store`=1) on unit u sets `st_busy[u]`. If any other unit holds a load, `st_stall[u]` is high from the cycle after acceptance.
- R5: An operation issued while only operations of its own kind are pending is not stalled.
- R6: A completion of a busy unit c clears every link that points at c. Any unit whose only link was to c is no longer stalled in the cycle after the completion.
- R7: A completion of a busy unit clears that unit's busy flag and its stall output in the cycle after the completion.
- R8: Links are recorded only at issue time. A unit is never stalled by an operation that was issued after it, and a unit never links to itself.
- R9: When a busy unit completes in the same cycle that another unit issues, the new operation records no link to the completing unit.
- R10: A completion that names an idle unit has no effect, even if an issue to that same unit is accepted in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | New memory operation offered |
| iss_ready | output | 1 | Addressed unit is idle and can take the offer |
| iss_unit | input | IDX_W | Index of the unit that receives the operation |
| iss_is_store | input | 1 | 1 = store, 0 = load |
| done_valid | input | 1 | Completion pulse |
| done_unit | input | IDX_W | Index of the completing unit |
| ld_busy | output | N_UNITS | Unit holds a pending load |
| st_busy | output | N_UNITS | Unit holds a pending store |
| ld_stall | output | N_UNITS | Unit's load must wait for older stores |
| st_stall | output | N_UNITS | Unit's store must wait for older loads |

## Verification
`iss_ready` is combinational from the registered busy flags and `iss_unit`. The bench checks it 1 ns after driving inputs at the falling edge, before the rising edge that could accept the offer. Busy flags, links and stall outputs all come from a single register stage, so the effect of an issue or a completion is due just after the next rising edge. The bench updates its arithmetic model at that edge and compares all four output vectors 1 ns later. A directed sequence walks through the ordering cases. A long pseudo-random sweep over four units, including same-cycle issue and completion, then checks every cycle.

// File: rtl/memdep_pkg.sv
package memdep_pkg;
  typedef enum logic {
    OP_LOAD  = 1'b0,
    OP_STORE = 1'b1
  } mem_op_e;
endpackage

// File: rtl/memdep_cell.sv
module memdep_cell #(
  parameter bit IS_DIAG = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_raw,
  input  logic set_war,
  input  logic clr,
  output logic raw_q,
  output logic war_q
);
  generate
    if (IS_DIAG) begin : g_diag
      // a unit never waits on itself
      assign raw_q = 1'b0;
      assign war_q = 1'b0;
    end else begin : g_live
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          raw_q <= 1'b0;
          war_q <= 1'b0;
        end else if (clr) begin
          raw_q <= 1'b0;
          war_q <= 1'b0;
        end else begin
          if (set_raw) raw_q <= 1'b1;
          if (set_war) war_q <= 1'b1;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/memdep_row.sv
module memdep_row
  import memdep_pkg::*;
#(
  parameter int N_UNITS = 4,
  parameter int ROW     = 0,
  localparam int IDX_W  = $clog2(N_UNITS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               iss_fire,
  input  logic [IDX_W-1:0]   iss_unit,
  input  mem_op_e            iss_op,
  input  logic               done_eff,
  input  logic [IDX_W-1:0]   done_unit,
  input  logic [N_UNITS-1:0] ld_pend,
  input  logic [N_UNITS-1:0] st_pend,
  output logic [N_UNITS-1:0] raw_vec,
  output logic [N_UNITS-1:0] war_vec
);
  logic row_hit;
  logic row_done;
  assign row_hit  = iss_fire && (iss_unit == IDX_W'(ROW));
  assign row_done = done_eff && (done_unit == IDX_W'(ROW));

  for (genvar c = 0; c < N_UNITS; c++) begin : g_col
    logic s_raw, s_war, c_clr;
    assign s_raw = row_hit && (iss_op == OP_LOAD)  && st_pend[c];
    assign s_war = row_hit && (iss_op == OP_STORE) && ld_pend[c];
    assign c_clr = row_done || (done_eff && (done_unit == IDX_W'(c)));
    memdep_cell #(.IS_DIAG(c == ROW)) u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_raw (s_raw),
      .set_war (s_war),
      .clr     (c_clr),
      .raw_q   (raw_vec[c]),
      .war_q   (war_vec[c])
    );
  end
endmodule

// File: rtl/memdep_pend.sv
module memdep_pend
  import memdep_pkg::*;
#(
  parameter int N_UNITS = 4,
  localparam int IDX_W  = $clog2(N_UNITS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               iss_fire,
  input  logic [IDX_W-1:0]   iss_unit,
  input  mem_op_e            iss_op,
  input  logic               done_eff,
  input  logic [IDX_W-1:0]   done_unit,
  output logic [N_UNITS-1:0] ld_pend,
  output logic [N_UNITS-1:0] st_pend
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ld_pend <= '0;
      st_pend <= '0;
    end else begin
      for (int i = 0; i < N_UNITS; i++) begin
        if (done_eff && done_unit == IDX_W'(i)) begin
          ld_pend[i] <= 1'b0;
          st_pend[i] <= 1'b0;
        end
        if (iss_fire && iss_unit == IDX_W'(i)) begin
          ld_pend[i] <= (iss_op == OP_LOAD);
          st_pend[i] <= (iss_op == OP_STORE);
        end
      end
    end
  end

  for (genvar i = 0; i < N_UNITS; i++) begin : g_chk
    // R2
    no_dual_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(ld_pend[i] && st_pend[i]));
    // R3
    load_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_fire && iss_unit == IDX_W'(i) && iss_op == OP_LOAD) |=> ld_pend[i]);
    // R7
    done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_eff && done_unit == IDX_W'(i)) |=> !(ld_pend[i] || st_pend[i]));
  end
endmodule

// File: rtl/memdep_matrix.sv
module memdep_matrix
  import memdep_pkg::*;
#(
  parameter int N_UNITS = 4,
  localparam int IDX_W  = $clog2(N_UNITS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               iss_valid,
  output logic               iss_ready,
  input  logic [IDX_W-1:0]   iss_unit,
  input  logic               iss_is_store,
  input  logic               done_valid,
  input  logic [IDX_W-1:0]   done_unit,
  output logic [N_UNITS-1:0] ld_busy,
  output logic [N_UNITS-1:0] st_busy,
  output logic [N_UNITS-1:0] ld_stall,
  output logic [N_UNITS-1:0] st_stall
);
  mem_op_e            iss_op;
  logic               iss_fire;
  logic               done_eff;
  logic [N_UNITS-1:0] busy;
  logic [N_UNITS-1:0] raw_m [N_UNITS];
  logic [N_UNITS-1:0] war_m [N_UNITS];

  assign iss_op    = iss_is_store ? OP_STORE : OP_LOAD;
  assign busy      = ld_busy | st_busy;
  assign iss_ready = !busy[iss_unit];
  assign iss_fire  = iss_valid && iss_ready;
  assign done_eff  = done_valid && busy[done_unit];

  memdep_pend #(.N_UNITS(N_UNITS)) u_pend (
    .clk       (clk),
    .rst_n     (rst_n),
    .iss_fire  (iss_fire),
    .iss_unit  (iss_unit),
    .iss_op    (iss_op),
    .done_eff  (done_eff),
    .done_unit (done_unit),
    .ld_pend   (ld_busy),
    .st_pend   (st_busy)
  );

  for (genvar r = 0; r < N_UNITS; r++) begin : g_row
    memdep_row #(.N_UNITS(N_UNITS), .ROW(r)) u_row (
      .clk       (clk),
      .rst_n     (rst_n),
      .iss_fire  (iss_fire),
      .iss_unit  (iss_unit),
      .iss_op    (iss_op),
      .done_eff  (done_eff),
      .done_unit (done_unit),
      .ld_pend   (ld_busy),
      .st_pend   (st_busy),
      .raw_vec   (raw_m[r]),
      .war_vec   (war_m[r])
    );
    assign ld_stall[r] = ld_busy[r] && (|raw_m[r]);
    assign st_stall[r] = st_busy[r] && (|war_m[r]);

    for (genvar c = 0; c < N_UNITS; c++) begin : g_chk
      // R3
      raw_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        raw_m[r][c] |-> (st_busy[c] && ld_busy[r]));
      // R4
      war_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        war_m[r][c] |-> (ld_busy[c] && st_busy[r]));
      // R6
      col_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_eff && done_unit == IDX_W'(c)) |=> !(raw_m[r][c] || war_m[r][c]));
      // R8
      no_late_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(iss_fire && iss_unit == IDX_W'(r)) && !raw_m[r][c]) |=> !raw_m[r][c]);
    end
  end

  // R2
  refuse_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_ready && !done_valid) |=> ($stable(ld_busy) && $stable(st_busy)));
endmodule

// File: tb/memdep_matrix_tb.sv
module memdep_matrix_tb_top;
  localparam int  N   = 4;
  localparam int  IW  = 2;
  localparam time CLK = 10ns;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          iss_valid = 1'b0, iss_is_store = 1'b0, done_valid = 1'b0;
  logic [IW-1:0] iss_unit = '0, done_unit = '0;
  logic          iss_ready;
  logic [N-1:0]  ld_busy, st_busy, ld_stall, st_stall;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  bit m_ld [N];
  bit m_st [N];
  bit m_raw [N][N];
  bit m_war [N][N];

  always #(CLK/2) clk = ~clk;

  memdep_matrix #(.N_UNITS(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_ready(iss_ready),
    .iss_unit(iss_unit), .iss_is_store(iss_is_store), .done_valid(done_valid),
    .done_unit(done_unit), .ld_busy(ld_busy), .st_busy(st_busy),
    .ld_stall(ld_stall), .st_stall(st_stall)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [4*N-1:0] model_out();
    logic [N-1:0] lb, sb, ls, ss;
    for (int r = 0; r < N; r++) begin
      bit anyr = 0, anyw = 0;
      for (int c = 0; c < N; c++) begin
        anyr |= m_raw[r][c];
        anyw |= m_war[r][c];
      end
      lb[r] = m_ld[r]; sb[r] = m_st[r];
      ls[r] = m_ld[r] && anyr; ss[r] = m_st[r] && anyw;
    end
    return {lb, sb, ls, ss};
  endfunction

  task automatic cyc(input bit v, input int u, input bit st, input bit dv, input int du,
                     input string tag);
    bit acc, deff;
    bit nld [N];
    bit nst [N];
    @(negedge clk);
    iss_valid = v; iss_unit = IW'(u); iss_is_store = st;
    done_valid = dv; done_unit = IW'(du);
    #1ns;
    check({tag, " ready"}, 32'(iss_ready), 32'(!(m_ld[u] || m_st[u])));
    acc  = v && !(m_ld[u] || m_st[u]);
    deff = dv && (m_ld[du] || m_st[du]);
    @(posedge clk);
    for (int r = 0; r < N; r++) begin
      for (int c = 0; c < N; c++) begin
        if (deff && (du == c || du == r)) begin
          m_raw[r][c] = 0; m_war[r][c] = 0;
        end else if (acc && r == u && r != c) begin
          if (!st) m_raw[r][c] |= m_st[c];
          else     m_war[r][c] |= m_ld[c];
        end
      end
    end
    for (int i = 0; i < N; i++) begin
      nld[i] = m_ld[i]; nst[i] = m_st[i];
      if (deff && du == i) begin nld[i] = 0; nst[i] = 0; end
      if (acc && u == i) begin nld[i] = !st; nst[i] = st; end
    end
    for (int i = 0; i < N; i++) begin m_ld[i] = nld[i]; m_st[i] = nst[i]; end
    #1ns;
    check({tag, " outputs"}, 32'({ld_busy, st_busy, ld_stall, st_stall}), 32'(model_out()));
  endtask

  initial begin
    #(CLK * 200000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    for (int i = 0; i < N; i++) begin
      m_ld[i] = 0; m_st[i] = 0;
      for (int j = 0; j < N; j++) begin m_raw[i][j] = 0; m_war[i][j] = 0; end
    end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1ns;
    // R1 reset state
    check("R1 outputs", 32'({ld_busy, st_busy, ld_stall, st_stall}), 32'h0);
    for (int u = 0; u < N; u++) begin
      iss_unit = IW'(u); #1ns;
      check("R1 ready", 32'(iss_ready), 32'h1);
    end
    cyc(1, 0, 0, 0, 0, "R5 load u0");
    cyc(1, 1, 0, 0, 0, "R5 load u1");
    check("R5 no stall", 32'(ld_stall), 32'h0);
    cyc(1, 2, 1, 0, 0, "R4 store u2");
    check("R4 store stalled", 32'(st_stall[2]), 32'h1);
    cyc(1, 3, 0, 0, 0, "R3 load u3");
    check("R3 load stalled", 32'(ld_stall[3]), 32'h1);
    check("R8 older load free", 32'(ld_stall[0]), 32'h0);
    cyc(1, 0, 1, 0, 0, "R2 refused busy u0");
    check("R2 u0 still load", 32'({ld_busy[0], st_busy[0]}), 32'h2);
    cyc(0, 0, 0, 1, 0, "R6 done u0");
    check("R6 u2 still waits on u1", 32'(st_stall[2]), 32'h1);
    cyc(0, 0, 0, 1, 1, "R6 done u1");
    check("R6 u2 released", 32'(st_stall[2]), 32'h0);
    check("R7 u1 idle", 32'({ld_busy[1], st_busy[1]}), 32'h0);
    cyc(1, 0, 0, 1, 0, "R10 done idle u0 with issue");
    check("R10 u0 load kept", 32'(ld_busy[0]), 32'h1);
    cyc(1, 1, 0, 1, 2, "R9 done u2 with load u1");
    check("R9 u1 not linked", 32'(ld_stall[1]), 32'h0);
    check("R6 u3 released", 32'(ld_stall[3]), 32'h0);
    for (int k = 0; k < 4000; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc(lfsr[0] | lfsr[1], int'(lfsr[3:2]), lfsr[4], lfsr[5] & lfsr[6],
          int'(lfsr[8:7]), "R3/R4/R6/R7/R8 sweep");
    end
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule